// File: doc/BRIEF.md
# AUX Request to I2C Transaction Sequencer

This block executes AUX-channel requests one at a time. A request names a command, a 20-bit address and a byte count, and its payload sits in a small internal byte buffer. A native request becomes a run of single-byte accesses on a register port. An I2C request becomes a sequence of start, byte and stop operations on a byte-level I2C master. When the work is finished, the block returns a two-bit reply code on a response stream.

Middle-of-transaction (MOT) I2C requests can leave the I2C bus open when they finish. The block records the command and address of the last MOT start. A later MOT request with the same command and address continues the open transfer without a new start. A change of command or address closes the transfer and opens a new one.

The host fills the buffer before issuing a write. It reads the buffer back after a read reply. All three streams use valid/ready. The request source must hold its fields stable while `req_valid` is high and `req_ready` is low. The block holds `rsp_valid` and `rsp_code` until `rsp_ready` is high. It holds each downstream operation, with all of its fields stable, until that port's ready is high. That ready cycle also carries the port's result.

Top module: `aux_i2c_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `nat_valid` and `i2c_valid` are 0. A request is accepted only while idle, and no second request is accepted before the reply of the first has been taken.
- R2: A native request is a command with bit 3 = 1 and bit 2 = 0. Bit 0 = 0 means write and bit 0 = 1 means read. It performs `req_cnt`+1 single-byte accesses, from 1 up to 16. Access i uses address `req_addr`+i and buffer slot i: a write takes its data from slot i, and a read stores its result into slot i.
- R3: On a native request, the first access that returns `nat_ok`=0 ends the request with no further access and reply 01 (NACK). If all accesses succeed, the reply is 00 (ACK).
- R4: An I2C request with bit 3 = 0 and bit 2 = 0 is a plain request. If an I2C transfer is open, the block first issues a stop (op 10). It then issues a start (op 00) with `i2c_dev` = `req_addr[6:0]` and `i2c_read` = command bit 0.
- R5: If a start returns `i2c_ack`=0, the request ends with reply 10 (I2C-NACK). No byte or stop operation follows, and the transfer counts as closed.
- R6: A plain I2C request moves its bytes with op 01. It stops at the first byte that returns `i2c_ack`=0. It always ends with one stop, then replies 10 on a failed byte or 00 on success.
- R7: An MOT request (bit 3 = 0, bit 2 = 1) opens with a start when no transfer is open. When a transfer is open and the command or the full 20-bit address differs from the stored one, it issues a stop and then a start. Otherwise it issues no start and goes straight to its bytes.
- R8: The command and address are stored only when the start of an MOT request succeeds. A later MOT request that matches them continues the open transfer.
- R9: An MOT request whose bytes all succeed leaves the transfer open and replies 00. A failed byte is followed by a stop and reply 10.
- R10: A command with bit 1 = 1, or with bits 3 and 2 both 1, is unsupported. It replies 01 in the cycle after acceptance and touches neither downstream port.
- R11: `rsp_valid` and `rsp_code` hold until `rsp_ready`. Host buffer writes made while a request is in progress or its reply is pending are ignored.
- R12: At most one downstream port is valid at a time. An operation that is not yet taken keeps valid high and its fields stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_cmd | input | 4 | Command: bit3 native, bit2 MOT, bits1:0 00 write / 01 read |
| req_addr | input | 20 | Native address or I2C address (low 7 bits used for the device) |
| req_cnt | input | 4 | Byte count minus one |
| rsp_valid | output | 1 | Reply available |
| rsp_ready | input | 1 | Reply taken |
| rsp_code | output | 2 | 00 ACK, 01 NACK, 10 I2C-NACK |
| buf_we | input | 1 | Host buffer write strobe (honoured only while idle) |
| buf_idx | input | 4 | Host buffer slot |
| buf_wdata | input | 8 | Host buffer write data |
| buf_rdata | output | 8 | Buffer slot `buf_idx` contents |
| nat_valid | output | 1 | Native access offered |
| nat_ready | input | 1 | Native access done, result valid |
| nat_write | output | 1 | Native access is a write |
| nat_addr | output | 20 | Native byte address |
| nat_wdata | output | 8 | Native write data |
| nat_ok | input | 1 | Native access succeeded |
| nat_rdata | input | 8 | Native read data |
| i2c_valid | output | 1 | I2C operation offered |
| i2c_ready | input | 1 | I2C operation done, result valid |
| i2c_op | output | 2 | 00 start, 01 byte, 10 stop |
| i2c_dev | output | 7 | Device address for a start |
| i2c_read | output | 1 | Direction of the current request |
| i2c_wdata | output | 8 | Byte to send |
| i2c_ack | input | 1 | Operation acknowledged |
| i2c_rdata | input | 8 | Byte received |

## Verification
Two pairs of functions can land in the same cycle. In the first pair, a pending reply held by back-pressure meets a host buffer write. The bench holds `rsp_ready` low while a reply waits, writes a buffer slot in that window, and then reads the slot back. It judges that the old byte is still there and that the reply code never moved. In the second pair, the close of an open MOT transfer and the open of the next one follow back to back with no idle cycle. A scoreboard of expected operations, built from a bench model of the open/last state, judges that stop and start come in the right order and only when command or address changed. Slow downstream responders stretch each handshake so that stalls overlap every state.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;

  typedef enum logic [1:0] {
    RSP_ACK      = 2'b00,
    RSP_NACK     = 2'b01,
    RSP_I2C_NACK = 2'b10
  } rsp_code_e;

  typedef enum logic [1:0] {
    OP_START = 2'b00,
    OP_BYTE  = 2'b01,
    OP_STOP  = 2'b10
  } i2c_op_e;

  typedef struct packed {
    logic legal;
    logic native;
    logic mot;
    logic rd;
  } cmd_info_t;

  function automatic cmd_info_t decode_cmd(input logic [3:0] c);
    cmd_info_t d;
    d.native = c[3];
    d.mot    = c[2];
    d.rd     = c[0];
    d.legal  = !c[1] && !(c[3] && c[2]);
    return d;
  endfunction

endpackage

// File: rtl/aux_seq_buf.sv
module aux_seq_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx_a,
  output logic [DW-1:0] rdata_a,
  input  logic [IW-1:0] ridx_b,
  output logic [DW-1:0] rdata_b
);

  logic [DEPTH-1:0]         sel;
  logic [DEPTH-1:0][DW-1:0] cell_q;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
      assign sel[g] = we && (widx == IW'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (sel[i]) cell_q[i] <= wdata;
      end
    end
  end

  assign rdata_a = cell_q[ridx_a];
  assign rdata_b = cell_q[ridx_b];

endmodule

// File: rtl/aux_seq_track.sv
module aux_seq_track #(
  parameter int AW = 20,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_set,
  input  logic          close,
  input  logic          remember,
  input  logic [CW-1:0] sto_cmd,
  input  logic [AW-1:0] sto_addr,
  input  logic [CW-1:0] cmp_cmd,
  input  logic [AW-1:0] cmp_addr,
  output logic          is_open,
  output logic          mismatch
);

  logic          open_q;
  logic [CW-1:0] last_cmd_q;
  logic [AW-1:0] last_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q      <= 1'b0;
      last_cmd_q  <= '0;
      last_addr_q <= '0;
    end else begin
      if (close)         open_q <= 1'b0;
      else if (open_set) open_q <= 1'b1;
      if (remember) begin
        last_cmd_q  <= sto_cmd;
        last_addr_q <= sto_addr;
      end
    end
  end

  assign is_open  = open_q;
  assign mismatch = (cmp_addr != last_addr_q) || (cmp_cmd != last_cmd_q);

endmodule

// File: rtl/aux_seq_ctrl.sv
module aux_seq_ctrl
  import aux_seq_pkg::*;
#(
  parameter int AW     = 20,
  parameter int DW     = 8,
  parameter int IW     = 4,
  parameter int DEV_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_cmd,
  input  logic [AW-1:0]    req_addr,
  input  logic [IW-1:0]    req_cnt,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [1:0]       rsp_code,
  output logic             nat_valid,
  input  logic             nat_ready,
  output logic             nat_write,
  output logic [AW-1:0]    nat_addr,
  input  logic             nat_ok,
  input  logic [DW-1:0]    nat_rdata,
  output logic             i2c_valid,
  input  logic             i2c_ready,
  output logic [1:0]       i2c_op,
  output logic [DEV_W-1:0] i2c_dev,
  output logic             i2c_read,
  input  logic             i2c_ack,
  input  logic [DW-1:0]    i2c_rdata,
  output logic [IW-1:0]    byte_idx,
  output logic             cap_we,
  output logic [DW-1:0]    cap_data,
  input  logic             trk_open,
  input  logic             trk_mismatch,
  output logic             trk_set,
  output logic             trk_close,
  output logic             trk_remember,
  output logic [3:0]       cur_cmd,
  output logic [AW-1:0]    cur_addr
);

  typedef enum logic [2:0] {
    S_IDLE, S_NAT, S_PRESTOP, S_START, S_XFER, S_POSTSTOP, S_REPLY
  } state_e;

  state_e        state_q;
  logic [3:0]    cmd_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] nat_addr_q;
  logic [IW-1:0] last_q;
  logic [IW-1:0] idx_q;
  rsp_code_e     code_q;
  cmd_info_t     dec_req;
  cmd_info_t     dec_q;

  logic take_req, nat_hs, i2c_hs, last_byte;

  assign dec_req   = decode_cmd(req_cmd);
  assign dec_q     = decode_cmd(cmd_q);
  assign take_req  = (state_q == S_IDLE) && req_valid;
  assign nat_hs    = nat_valid && nat_ready;
  assign i2c_hs    = i2c_valid && i2c_ready;
  assign last_byte = (idx_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      cmd_q      <= '0;
      addr_q     <= '0;
      nat_addr_q <= '0;
      last_q     <= '0;
      idx_q      <= '0;
      code_q     <= RSP_ACK;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (take_req) begin
            cmd_q      <= req_cmd;
            addr_q     <= req_addr;
            nat_addr_q <= req_addr;
            last_q     <= req_cnt;
            idx_q      <= '0;
            code_q     <= RSP_ACK;
            if (!dec_req.legal) begin
              code_q  <= RSP_NACK;
              state_q <= S_REPLY;
            end else if (dec_req.native) begin
              state_q <= S_NAT;
            end else if (!dec_req.mot) begin
              state_q <= trk_open ? S_PRESTOP : S_START;
            end else if (!trk_open) begin
              state_q <= S_START;
            end else if (trk_mismatch) begin
              state_q <= S_PRESTOP;
            end else begin
              state_q <= S_XFER;
            end
          end
        end
        S_NAT: begin
          if (nat_hs) begin
            if (!nat_ok) begin
              code_q  <= RSP_NACK;
              state_q <= S_REPLY;
            end else if (last_byte) begin
              code_q  <= RSP_ACK;
              state_q <= S_REPLY;
            end else begin
              idx_q      <= idx_q + 1'b1;
              nat_addr_q <= nat_addr_q + 1'b1;
            end
          end
        end
        S_PRESTOP: begin
          if (i2c_hs) state_q <= S_START;
        end
        S_START: begin
          if (i2c_hs) begin
            if (!i2c_ack) begin
              code_q  <= RSP_I2C_NACK;
              state_q <= S_REPLY;
            end else begin
              state_q <= S_XFER;
            end
          end
        end
        S_XFER: begin
          if (i2c_hs) begin
            if (!i2c_ack) begin
              code_q  <= RSP_I2C_NACK;
              state_q <= S_POSTSTOP;
            end else if (last_byte) begin
              code_q  <= RSP_ACK;
              state_q <= dec_q.mot ? S_REPLY : S_POSTSTOP;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        S_POSTSTOP: begin
          if (i2c_hs) state_q <= S_REPLY;
        end
        S_REPLY: begin
          if (rsp_ready) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // request / reply streams
  assign req_ready = (state_q == S_IDLE);
  assign rsp_valid = (state_q == S_REPLY);
  assign rsp_code  = code_q;

  // native port
  assign nat_valid = (state_q == S_NAT);
  assign nat_write = !dec_q.rd;
  assign nat_addr  = nat_addr_q;

  // I2C command port
  always_comb begin
    i2c_valid = 1'b0;
    i2c_op    = OP_BYTE;
    unique case (state_q)
      S_PRESTOP, S_POSTSTOP: begin
        i2c_valid = 1'b1;
        i2c_op    = OP_STOP;
      end
      S_START: begin
        i2c_valid = 1'b1;
        i2c_op    = OP_START;
      end
      S_XFER: begin
        i2c_valid = 1'b1;
        i2c_op    = OP_BYTE;
      end
      default: ;
    endcase
  end
  assign i2c_dev  = addr_q[DEV_W-1:0];
  assign i2c_read = dec_q.rd;

  // buffer capture of read data
  assign byte_idx = idx_q;
  always_comb begin
    cap_we   = 1'b0;
    cap_data = nat_rdata;
    if (nat_hs && nat_ok && dec_q.rd) begin
      cap_we = 1'b1;
    end else if (state_q == S_XFER && i2c_hs && i2c_ack && dec_q.rd) begin
      cap_we   = 1'b1;
      cap_data = i2c_rdata;
    end
  end

  // open-transfer tracker controls
  assign trk_set      = (state_q == S_START) && i2c_hs && i2c_ack;
  assign trk_remember = trk_set && dec_q.mot;
  assign trk_close    = ((state_q == S_PRESTOP || state_q == S_POSTSTOP) && i2c_hs) ||
                        ((state_q == S_START) && i2c_hs && !i2c_ack);
  assign cur_cmd      = cmd_q;
  assign cur_addr     = addr_q;

endmodule

// File: rtl/aux_i2c_seq.sv
module aux_i2c_seq #(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 8,
  parameter int BUF_DEPTH = 16,
  parameter int DEV_W     = 7,
  localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [IDX_W-1:0]  req_cnt,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_code,
  input  logic              buf_we,
  input  logic [IDX_W-1:0]  buf_idx,
  input  logic [DATA_W-1:0] buf_wdata,
  output logic [DATA_W-1:0] buf_rdata,
  output logic              nat_valid,
  input  logic              nat_ready,
  output logic              nat_write,
  output logic [ADDR_W-1:0] nat_addr,
  output logic [DATA_W-1:0] nat_wdata,
  input  logic              nat_ok,
  input  logic [DATA_W-1:0] nat_rdata,
  output logic              i2c_valid,
  input  logic              i2c_ready,
  output logic [1:0]        i2c_op,
  output logic [DEV_W-1:0]  i2c_dev,
  output logic              i2c_read,
  output logic [DATA_W-1:0] i2c_wdata,
  input  logic              i2c_ack,
  input  logic [DATA_W-1:0] i2c_rdata
);

  logic [IDX_W-1:0]  byte_idx;
  logic              cap_we;
  logic [DATA_W-1:0] cap_data;
  logic [DATA_W-1:0] cur_byte;
  logic              trk_open, trk_mismatch, trk_set, trk_close, trk_remember;
  logic [3:0]        cur_cmd;
  logic [ADDR_W-1:0] cur_addr;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;

  // internal capture owns the write port while busy; host writes only while idle
  assign wr_en   = cap_we || (buf_we && req_ready);
  assign wr_idx  = cap_we ? byte_idx : buf_idx;
  assign wr_data = cap_we ? cap_data : buf_wdata;

  aux_seq_buf #(
    .DEPTH (BUF_DEPTH),
    .DW    (DATA_W)
  ) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_en),
    .widx    (wr_idx),
    .wdata   (wr_data),
    .ridx_a  (buf_idx),
    .rdata_a (buf_rdata),
    .ridx_b  (byte_idx),
    .rdata_b (cur_byte)
  );

  aux_seq_track #(
    .AW (ADDR_W),
    .CW (4)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .open_set (trk_set),
    .close    (trk_close),
    .remember (trk_remember),
    .sto_cmd  (cur_cmd),
    .sto_addr (cur_addr),
    .cmp_cmd  (req_cmd),
    .cmp_addr (req_addr),
    .is_open  (trk_open),
    .mismatch (trk_mismatch)
  );

  aux_seq_ctrl #(
    .AW    (ADDR_W),
    .DW    (DATA_W),
    .IW    (IDX_W),
    .DEV_W (DEV_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_cmd      (req_cmd),
    .req_addr     (req_addr),
    .req_cnt      (req_cnt),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_code     (rsp_code),
    .nat_valid    (nat_valid),
    .nat_ready    (nat_ready),
    .nat_write    (nat_write),
    .nat_addr     (nat_addr),
    .nat_ok       (nat_ok),
    .nat_rdata    (nat_rdata),
    .i2c_valid    (i2c_valid),
    .i2c_ready    (i2c_ready),
    .i2c_op       (i2c_op),
    .i2c_dev      (i2c_dev),
    .i2c_read     (i2c_read),
    .i2c_ack      (i2c_ack),
    .i2c_rdata    (i2c_rdata),
    .byte_idx     (byte_idx),
    .cap_we       (cap_we),
    .cap_data     (cap_data),
    .trk_open     (trk_open),
    .trk_mismatch (trk_mismatch),
    .trk_set      (trk_set),
    .trk_close    (trk_close),
    .trk_remember (trk_remember),
    .cur_cmd      (cur_cmd),
    .cur_addr     (cur_addr)
  );

  assign nat_wdata = cur_byte;
  assign i2c_wdata = cur_byte;

endmodule

// File: rtl/aux_i2c_seq_chk.sv
module aux_i2c_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [3:0]        req_cmd,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_code,
  input logic              nat_valid,
  input logic              nat_ready,
  input logic              nat_write,
  input logic [ADDR_W-1:0] nat_addr,
  input logic [DATA_W-1:0] nat_wdata,
  input logic              nat_ok,
  input logic              i2c_valid,
  input logic              i2c_ready,
  input logic [1:0]        i2c_op,
  input logic              i2c_ack
);

  logic unsupported;
  assign unsupported = req_cmd[1] || (req_cmd[3] && req_cmd[2]);

  // R1: idle means no downstream activity and no pending reply
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!nat_valid && !i2c_valid && !rsp_valid));

  // R2: each successful native access that is followed by another steps the address by one
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (nat_valid && nat_ready && nat_ok) |=>
      (!nat_valid || (nat_addr == ($past(nat_addr) + {{(ADDR_W-1){1'b0}}, 1'b1}))));

  // R3: a failed native access ends the request with NACK
  a_r3_nat_fail_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (nat_valid && nat_ready && !nat_ok) |=> (!nat_valid && rsp_valid && rsp_code == 2'b01));

  // R5: a refused start ends the request with I2C-NACK and no further operation
  a_r5_start_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_valid && i2c_ready && i2c_op == 2'b00 && !i2c_ack) |=>
      (!i2c_valid && rsp_valid && rsp_code == 2'b10));

  // R10: unsupported commands reply NACK at once without port activity
  a_r10_unsupported: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && unsupported) |=>
      (rsp_valid && rsp_code == 2'b01 && !nat_valid && !i2c_valid));

  // R11: reply held until taken
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code)));

  // R12: only one downstream port active
  a_r12_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(nat_valid && i2c_valid));

  // R12: native operation held stable until taken
  a_r12_nat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (nat_valid && !nat_ready) |=>
      (nat_valid && $stable(nat_addr) && $stable(nat_write) && $stable(nat_wdata)));

  // R12: I2C operation held stable until taken
  a_r12_i2c_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_valid && !i2c_ready) |=> (i2c_valid && $stable(i2c_op)));

endmodule

bind aux_i2c_seq aux_i2c_seq_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_cmd   (req_cmd),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_code  (rsp_code),
  .nat_valid (nat_valid),
  .nat_ready (nat_ready),
  .nat_write (nat_write),
  .nat_addr  (nat_addr),
  .nat_wdata (nat_wdata),
  .nat_ok    (nat_ok),
  .i2c_valid (i2c_valid),
  .i2c_ready (i2c_ready),
  .i2c_op    (i2c_op),
  .i2c_ack   (i2c_ack)
);

// File: tb/aux_i2c_seq_bench.sv
module aux_i2c_seq_bench;
  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] K_NW = 4'd1, K_NR = 4'd2, K_ST = 4'd3,
                         K_BW = 4'd4, K_BR = 4'd5, K_SP = 4'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_cmd = '0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_cnt = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_code;
  logic        buf_we = 1'b0;
  logic [3:0]  buf_idx = '0;
  logic [7:0]  buf_wdata = '0;
  logic [7:0]  buf_rdata;
  logic        nat_valid;
  logic        nat_ready = 1'b0;
  logic        nat_write;
  logic [19:0] nat_addr;
  logic [7:0]  nat_wdata;
  logic        nat_ok = 1'b0;
  logic [7:0]  nat_rdata = '0;
  logic        i2c_valid;
  logic        i2c_ready = 1'b0;
  logic [1:0]  i2c_op;
  logic [6:0]  i2c_dev;
  logic        i2c_read;
  logic [7:0]  i2c_wdata;
  logic        i2c_ack = 1'b0;
  logic [7:0]  i2c_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_i2c_seq u_aux_i2c_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_cnt(req_cnt),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .nat_valid(nat_valid), .nat_ready(nat_ready), .nat_write(nat_write),
    .nat_addr(nat_addr), .nat_wdata(nat_wdata), .nat_ok(nat_ok), .nat_rdata(nat_rdata),
    .i2c_valid(i2c_valid), .i2c_ready(i2c_ready), .i2c_op(i2c_op), .i2c_dev(i2c_dev),
    .i2c_read(i2c_read), .i2c_wdata(i2c_wdata), .i2c_ack(i2c_ack), .i2c_rdata(i2c_rdata)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string tag = "R1";

  logic [31:0] exp_ops[$];
  logic [1:0]  exp_rsp[$];
  logic [7:0]  rd_rec[$];
  logic [7:0]  hbuf[16];
  logic [7:0]  mem[256];

  // device model configuration
  bit          slow = 1'b0;
  bit          ph = 1'b0;
  bit          nat_fail_en = 1'b0;
  logic [19:0] nat_fail_addr = '0;
  bit          nak_en = 1'b0;
  logic [6:0]  nak_dev = '0;
  int          bytes_total = 0;
  int          fail_at = -1;

  // bench prediction state
  bit          p_open = 1'b0;
  logic [3:0]  p_last_cmd = '0;
  logic [19:0] p_last_addr = '0;
  int          p_bytes = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic log_op(input logic [31:0] w);
    logic [31:0] e;
    if (exp_ops.size() == 0) begin
      check(1'b0, tag, "unexpected downstream operation", w, 0);
    end else begin
      e = exp_ops.pop_front();
      check(w == e, tag, "downstream operation", w, e);
    end
  endtask

  // downstream responders and reply monitor, all at the falling edge
  always @(negedge clk) begin
    logic ok;
    ph = ~ph;
    nat_ready = 1'b0;
    i2c_ready = 1'b0;
    if (rst_n && nat_valid && (!slow || ph)) begin
      ok = !(nat_fail_en && nat_addr == nat_fail_addr);
      nat_ready = 1'b1;
      nat_ok    = ok;
      nat_rdata = mem[nat_addr[7:0]];
      if (ok && nat_write) mem[nat_addr[7:0]] = nat_wdata;
      if (ok && !nat_write) rd_rec.push_back(mem[nat_addr[7:0]]);
      log_op({nat_write ? K_NW : K_NR, nat_addr, nat_write ? nat_wdata : 8'h00});
    end
    if (rst_n && i2c_valid && (!slow || ph)) begin
      i2c_ready = 1'b1;
      case (i2c_op)
        2'b00: begin
          i2c_ack = !(nak_en && i2c_dev == nak_dev);
          log_op({K_ST, 13'h0, i2c_dev, 7'h0, i2c_read});
        end
        2'b01: begin
          i2c_ack   = (bytes_total != fail_at);
          i2c_rdata = 8'h3C ^ bytes_total[7:0];
          if (i2c_ack && i2c_read) rd_rec.push_back(i2c_rdata);
          bytes_total++;
          log_op({i2c_read ? K_BR : K_BW, 20'h0, i2c_read ? 8'h00 : i2c_wdata});
        end
        default: begin
          i2c_ack = 1'b1;
          log_op({K_SP, 28'h0});
        end
      endcase
    end
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_rsp.size() == 0) begin
        check(1'b0, tag, "unexpected reply", rsp_code, 0);
      end else begin
        logic [1:0] e;
        e = exp_rsp.pop_front();
        check(rsp_code == e, tag, "reply code", rsp_code, e);
      end
    end
  end

  // driver side: predict operations and reply from the requirements
  task automatic predict(input logic [3:0] c, input logic [19:0] a, input int n);
    bit native, mot, rd, bad, do_start, failed;
    logic [19:0] na;
    native = c[3]; mot = c[2]; rd = c[0];
    bad = c[1] || (c[3] && c[2]);
    if (bad) begin
      exp_rsp.push_back(2'b01);
      return;
    end
    if (native) begin
      failed = 1'b0;
      for (int i = 0; i < n; i++) begin
        na = a + 20'(i);
        exp_ops.push_back({rd ? K_NR : K_NW, na, rd ? 8'h00 : hbuf[i]});
        if (nat_fail_en && na == nat_fail_addr) begin
          failed = 1'b1;
          break;
        end
      end
      exp_rsp.push_back(failed ? 2'b01 : 2'b00);
      return;
    end
    do_start = 1'b0;
    if (!mot) begin
      if (p_open) exp_ops.push_back({K_SP, 28'h0});
      do_start = 1'b1;
    end else if (!p_open) begin
      do_start = 1'b1;
    end else if (a != p_last_addr || c != p_last_cmd) begin
      exp_ops.push_back({K_SP, 28'h0});
      do_start = 1'b1;
    end
    if (do_start) begin
      exp_ops.push_back({K_ST, 13'h0, a[6:0], 7'h0, rd});
      if (nak_en && a[6:0] == nak_dev) begin
        p_open = 1'b0;
        exp_rsp.push_back(2'b10);
        return;
      end
      p_open = 1'b1;
      if (mot) begin
        p_last_cmd  = c;
        p_last_addr = a;
      end
    end
    failed = 1'b0;
    for (int i = 0; i < n; i++) begin
      exp_ops.push_back({rd ? K_BR : K_BW, 20'h0, rd ? 8'h00 : hbuf[i]});
      if (p_bytes == fail_at) failed = 1'b1;
      p_bytes++;
      if (failed) break;
    end
    if (!mot || failed) begin
      exp_ops.push_back({K_SP, 28'h0});
      p_open = 1'b0;
    end
    exp_rsp.push_back(failed ? 2'b10 : 2'b00);
  endtask

  task automatic send(input logic [3:0] c, input logic [19:0] a, input int n);
    @(posedge clk); #1;
    req_valid = 1'b1; req_cmd = c; req_addr = a; req_cnt = 4'(n - 1);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic run(input logic [3:0] c, input logic [19:0] a, input int n, input string t);
    tag = t;
    rd_rec.delete();
    predict(c, a, n);
    send(c, a, n);
    while (exp_rsp.size() != 0) @(negedge clk);
    check(exp_ops.size() == 0, t, "operations still missing", exp_ops.size(), 0);
  endtask

  task automatic host_wr(input int i, input logic [7:0] v);
    @(posedge clk); #1;
    buf_we = 1'b1; buf_idx = 4'(i); buf_wdata = v;
    @(posedge clk); #1;
    buf_we = 1'b0;
  endtask

  task automatic chk_buf(input int i, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    buf_idx = 4'(i);
    @(negedge clk);
    check(buf_rdata == e, t, $sformatf("buffer slot %0d", i), buf_rdata, e);
  endtask

  task automatic chk_reads(input string t);
    for (int i = 0; i < rd_rec.size(); i++) chk_buf(i, rd_rec[i], t);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, tag, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h55;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    check(nat_valid == 1'b0 && i2c_valid == 1'b0, "R1", "ports idle after reset",
          {nat_valid, i2c_valid}, 0);

    for (int i = 0; i < 16; i++) begin
      hbuf[i] = 8'h10 + 8'(i);
      host_wr(i, hbuf[i]);
    end

    // R2: native write then read back through the buffer
    run(4'b1000, 20'h00010, 4, "R2");
    run(4'b1001, 20'h00010, 4, "R2");
    chk_reads("R2");

    // R3: failure on the second byte stops the request
    nat_fail_en = 1'b1; nat_fail_addr = 20'h00021;
    run(4'b1000, 20'h00020, 3, "R3");
    nat_fail_en = 1'b0;

    // R10: unsupported commands
    run(4'b0010, 20'h00050, 1, "R10");
    run(4'b1110, 20'h00050, 1, "R10");
    run(4'b1100, 20'h00050, 2, "R10");

    // R4 / R6: plain I2C write, then failing first byte
    run(4'b0000, 20'h00050, 2, "R6");
    fail_at = p_bytes;
    run(4'b0000, 20'h00050, 3, "R6");
    fail_at = -1;

    // R5: refused start on a plain read
    nak_en = 1'b1; nak_dev = 7'h33;
    run(4'b0001, 20'h00033, 2, "R5");
    nak_en = 1'b0;

    // R7 / R8: MOT open, continue, restart on command, restart on address
    run(4'b0100, 20'h00050, 2, "R7");
    run(4'b0100, 20'h00050, 2, "R8");
    run(4'b0101, 20'h00050, 3, "R7");
    chk_reads("R7");
    run(4'b0101, 20'h00051, 1, "R7");
    // R4: plain read while an MOT transfer is open
    run(4'b0001, 20'h00051, 2, "R4");
    chk_reads("R4");

    // refill the buffer after reads changed it
    for (int i = 0; i < 16; i++) host_wr(i, hbuf[i]);

    // R9: MOT byte failure closes, next MOT request starts anew
    run(4'b0100, 20'h00060, 2, "R9");
    fail_at = p_bytes + 1;
    run(4'b0100, 20'h00060, 3, "R9");
    fail_at = -1;
    run(4'b0100, 20'h00060, 1, "R9");

    // R5 / R8: refused MOT start leaves closed, retry starts again
    nak_en = 1'b1; nak_dev = 7'h33;
    run(4'b0100, 20'h00033, 1, "R5");
    nak_en = 1'b0;
    run(4'b0100, 20'h00033, 1, "R8");

    // R12: slow responders, full-length native write and MOT read
    slow = 1'b1;
    run(4'b1000, 20'h00080, 16, "R12");
    run(4'b0101, 20'h00033, 4, "R12");
    chk_reads("R12");
    run(4'b0001, 20'h00033, 1, "R12");
    slow = 1'b0;
    for (int i = 0; i < 16; i++) host_wr(i, hbuf[i]);

    // R11: reply held under back-pressure, host write during it ignored
    tag = "R11";
    rsp_ready = 1'b0;
    rd_rec.delete();
    predict(4'b1000, 20'h00040, 2);
    send(4'b1000, 20'h00040, 2);
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    host_wr(0, 8'hEE);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(rsp_valid == 1'b1 && rsp_code == 2'b00, "R11", "reply held",
            {rsp_valid, rsp_code}, 3'b100);
    end
    @(posedge clk); #1;
    rsp_ready = 1'b1;
    while (exp_rsp.size() != 0) @(negedge clk);
    chk_buf(0, hbuf[0], "R11");

    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule